// File: doc/BRIEF.md
# Sync-Gated Configuration Commit Controller

This block holds the configuration of a four-channel processing datapath and decides the cycle on which new settings reach it. A processor writes through a plain address/data/write-enable port. Each write is first registered into the processing clock and then lands in a shadow copy of its register group, which marks that group as pending. The active copy, which drives the datapath, picks up the shadow value only on a sync event. Every channel therefore sees a new setting on the same cycle.

Two asynchronous sync inputs each pass through a two-flop synchronizer and a rising-edge detector, giving a one-cycle event. One input is meant to recur often, for example at slot boundaries. The other is meant to be rare, for example at start-up or once per second. A control register assigns each register group to one of the two sources. It also gates each source on or off and picks which source releases processing after reset. Until that first event, every channel's processing enable stays low. On that event all channels start together and stay running.

The control register is not shadowed. A write to it takes effect one cycle after it is registered, so software should change it in the gap between sync events. Reads return the active value of a group, never its pending shadow value.

Top module: `sync_commit_ctrl`

## Requirements
- R1: After reset, every active group value is 0, nothing is pending, `proc_en` is all zero, and the control register reads 0x0003_0000.
- R2: A write to group g (address g, for g below NUM_GRP) does not change the read-back value or `cfg_active` until a sync event from the group's selected source.
- R3: A sync event from a source that is not selected for a group leaves that group's active value unchanged.
- R4: Control register bit g selects the source for group g. A value of 0 selects sync 1 and a value of 1 selects sync 2. The control register is at address 0x10.
- R5: A sync input held high produces one event only. A write made while it stays high is not committed until the next rising edge.
- R6: When a registered write to a group and that group's sync event fall on the same cycle, the previous shadow value is committed. The new value stays pending until the following event.
- R7: `proc_en` stays 0 until the first event of the start source, which is set by control bit 8 (0 selects sync 1, 1 selects sync 2). All channels then go high on the same cycle and remain high until reset.
- R8: Control bits 16 (sync 1) and 17 (sync 2) enable each source. Events from a disabled source commit nothing and do not start processing.
- R9: The new active value appears on the third rising clock edge after a sync input rises.
- R10: All pending groups that select the same source commit on the same clock edge.
- R11: Writes to unmapped addresses change nothing, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync1_in | input | 1 | Asynchronous sync input 1 (frequent) |
| sync2_in | input | 1 | Asynchronous sync input 2 (infrequent) |
| wr_en | input | 1 | Processor write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 32 | Active value at rd_addr (combinational) |
| cfg_active | output | NUM_GRP*32 | Active group values, group g at bits [32g+31:32g] |
| proc_en | output | NUM_CH | Per-channel processing enable |

## Verification
The bench targets a write that collides with its own sync event. A design that gets this wrong either commits the new value at once or loses it. The bench holds a sync line high across a second write; a level-sensitive design would commit that write early. It counts clock edges from a sync rise to the visible change, so an extra or a missing synchronizer stage shows up as a one-cycle shift. It also checks that a disabled source or an unselected source starts nothing and commits nothing, since a design that ignores the enable or the group's source bit would change the outputs.

// File: rtl/sync_commit_pkg.sv
package sync_commit_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h10;
  localparam int START_SRC_BIT = 8;
  localparam int SRC_EN_LSB = 16;
  localparam int NUM_SRC = 2;
  localparam logic [DATA_W-1:0] CTRL_RST = 32'h0003_0000;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic pulse
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
      last <= 1'b0;
    end else begin
      pipe <= {pipe[STAGES-2:0], async_in};
      last <= pipe[STAGES-1];
    end
  end

  assign pulse = pipe[STAGES-1] & ~last;
endmodule

// File: rtl/shadow_group.sv
module shadow_group
  import sync_commit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  output logic [DATA_W-1:0] active
);
  logic [DATA_W-1:0] shadow;
  logic              armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
      armed  <= 1'b0;
    end else begin
      // Commit first, using the shadow value from before this edge.
      if (commit && armed) active <= shadow;
      if (wr_hit) begin
        shadow <= wr_data;
        armed  <= 1'b1;
      end else if (commit) begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/start_align.sv
module start_align #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic [NUM_CH-1:0] started
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  started[c] <= 1'b0;
      else if (go) started[c] <= 1'b1;
    end
  end
endmodule

// File: rtl/sync_commit_ctrl.sv
module sync_commit_ctrl
  import sync_commit_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_GRP = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sync1_in,
  input  logic                      sync2_in,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_GRP*DATA_W-1:0] cfg_active,
  output logic [NUM_CH-1:0]         proc_en
);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'((1 << NUM_GRP) - 1) | (DATA_W'(1) << START_SRC_BIT) |
    (DATA_W'((1 << NUM_SRC) - 1) << SRC_EN_LSB);

  wr_req_t              wr_q;
  logic [DATA_W-1:0]    ctrl;
  logic [NUM_SRC-1:0]   s_pulse;
  logic [NUM_SRC-1:0]   src_evt;
  logic [NUM_SRC-1:0]   sync_raw;
  logic [NUM_GRP-1:0]   grp_commit;
  logic                 start_go;

  assign sync_raw = {sync2_in, sync1_in};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sync
    sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .async_in(sync_raw[s]), .pulse(s_pulse[s])
    );
  end

  // Processor write stage into the processing clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
    end else begin
      wr_q.vld  <= wr_en;
      wr_q.addr <= wr_addr;
      wr_q.data <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl <= CTRL_RST;
    else if (wr_q.vld && wr_q.addr == CTRL_ADDR)
      ctrl <= wr_q.data & CTRL_MASK;
  end

  assign src_evt  = s_pulse & ctrl[SRC_EN_LSB +: NUM_SRC];
  assign start_go = ctrl[START_SRC_BIT] ? src_evt[1] : src_evt[0];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    assign hit           = wr_q.vld && (wr_q.addr == ADDR_W'(g));
    assign grp_commit[g] = ctrl[g] ? src_evt[1] : src_evt[0];
    shadow_group u_grp (
      .clk(clk), .rst_n(rst_n), .wr_hit(hit), .wr_data(wr_q.data),
      .commit(grp_commit[g]), .active(cfg_active[g*DATA_W +: DATA_W])
    );
  end

  start_align #(.NUM_CH(NUM_CH)) u_start (
    .clk(clk), .rst_n(rst_n), .go(start_go), .started(proc_en)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_ADDR) begin
      rd_data = ctrl;
    end else begin
      for (int g = 0; g < NUM_GRP; g++)
        if (rd_addr == ADDR_W'(g)) rd_data = cfg_active[g*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/sync_commit_chk.sv
module sync_commit_chk
  import sync_commit_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_GRP = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC-1:0]        s_pulse,
  input logic [NUM_GRP*DATA_W-1:0] cfg_active,
  input logic [NUM_CH-1:0]         proc_en,
  input logic [ADDR_W-1:0]         rd_addr,
  input logic [DATA_W-1:0]         rd_data
);
  // R2, R3: active values move only on the edge that follows a sync event.
  assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_pulse == '0) |=> $stable(cfg_active));

  // R5: the edge detector yields single-cycle events.
  assert_single_evt1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_pulse[0] |=> !s_pulse[0]);
  assert_single_evt2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_pulse[1] |=> !s_pulse[1]);

  // R7: channels start together and stay started.
  assert_start_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_en == '0) || (proc_en == '1));
  assert_start_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_en != '0) |=> (proc_en == '1));
  assert_start_needs_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proc_en[0]) |-> $past(s_pulse != '0));

  // R11: unmapped reads return zero.
  assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != CTRL_ADDR && int'(rd_addr) >= NUM_GRP) |-> (rd_data == '0));
endmodule

bind sync_commit_ctrl sync_commit_chk #(.NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_pulse(s_pulse), .cfg_active(cfg_active),
  .proc_en(proc_en), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sync_commit_ctrl_test.sv
module sync_commit_ctrl_test;
  localparam int NCH = 4;
  localparam int NGRP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync1_in = 1'b0, sync2_in = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [NGRP*32-1:0] cfg_active;
  logic [NCH-1:0] proc_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_commit_ctrl #(.NUM_CH(NCH), .NUM_GRP(NGRP)) uut (
    .clk(clk), .rst_n(rst_n), .sync1_in(sync1_in), .sync2_in(sync2_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .cfg_active(cfg_active), .proc_en(proc_en)
  );

  // op: 0 write, 1 sync1 event, 2 sync2 event, 3 read check, 4 proc_en check
  localparam int NV = 26;
  localparam logic [43:0] VEC [NV] = '{
    {4'd0, 8'h00, 32'hA1A1_0001},
    {4'd3, 8'h00, 32'h0000_0000},  // R2 pending, not visible
    {4'd2, 8'h00, 32'h0},
    {4'd3, 8'h00, 32'h0000_0000},  // R3 wrong source
    {4'd4, 8'h00, 32'h0},          // R7 no start on sync2
    {4'd1, 8'h00, 32'h0},
    {4'd3, 8'h00, 32'hA1A1_0001},  // R3 committed
    {4'd4, 8'h00, 32'hF},          // R7 started
    {4'd0, 8'h10, 32'h0003_0002},
    {4'd3, 8'h10, 32'h0003_0002},  // R4
    {4'd0, 8'h01, 32'hB2B2_0002},
    {4'd0, 8'h00, 32'hC3C3_0003},
    {4'd1, 8'h00, 32'h0},
    {4'd3, 8'h01, 32'h0000_0000},  // R4 g1 on sync2
    {4'd3, 8'h00, 32'hC3C3_0003},  // R4 g0 on sync1
    {4'd2, 8'h00, 32'h0},
    {4'd3, 8'h01, 32'hB2B2_0002},  // R4
    {4'd0, 8'h05, 32'hDEAD_0005},
    {4'd3, 8'h05, 32'h0000_0000},  // R11
    {4'd3, 8'h10, 32'h0003_0002},  // R11 ctrl untouched
    {4'd0, 8'h10, 32'h0002_0002},
    {4'd0, 8'h00, 32'hD4D4_0004},
    {4'd1, 8'h00, 32'h0},
    {4'd3, 8'h00, 32'hC3C3_0003},  // R8 sync1 disabled
    {4'd0, 8'h10, 32'h0003_0002},
    {4'd1, 8'h00, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_sync(input int s);
    @(negedge clk);
    if (s == 1) sync1_in = 1'b1; else sync2_in = 1'b1;
    repeat (3) @(negedge clk);
    sync1_in = 1'b0; sync2_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); rd_addr = a; #1;
    check(req, rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 proc_en", {28'h0, proc_en}, 32'h0);
    check("R1 cfg_active g0", cfg_active[31:0], 32'h0);
    read_chk("R1 ctrl", 8'h10, 32'h0003_0000);
    read_chk("R1 g3", 8'h03, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][43:40])
        4'd0: do_write(VEC[i][39:32], VEC[i][31:0]);
        4'd1: do_sync(1);
        4'd2: do_sync(2);
        4'd3: read_chk("R2/R3/R4/R8/R11 table read", VEC[i][39:32], VEC[i][31:0]);
        default: begin @(negedge clk); check("R7 table proc_en", {28'h0, proc_en}, VEC[i][31:0]); end
      endcase
    end
    read_chk("R8 re-enabled commit", 8'h00, 32'hD4D4_0004);

    // R9 latency, R10 simultaneous commit (g0 and g2 both on sync1)
    do_write(8'h00, 32'hE5E5_0005);
    do_write(8'h02, 32'hF6F6_0006);
    @(negedge clk); sync1_in = 1'b1;
    @(negedge clk);
    check("R9 edge1 unchanged", cfg_active[31:0], 32'hD4D4_0004);
    @(negedge clk);
    check("R9 edge2 unchanged", cfg_active[31:0], 32'hD4D4_0004);
    check("R10 edge2 g2 unchanged", cfg_active[95:64], 32'h0);
    @(negedge clk);
    check("R9 edge3 committed", cfg_active[31:0], 32'hE5E5_0005);
    check("R10 g2 same edge", cfg_active[95:64], 32'hF6F6_0006);
    // R5: held high, a new write must not commit
    do_write(8'h00, 32'h1111_0001);
    repeat (4) @(negedge clk);
    check("R5 held level no commit", cfg_active[31:0], 32'hE5E5_0005);
    sync1_in = 1'b0;
    repeat (3) @(negedge clk);
    do_sync(1);
    check("R5 next rise commits", cfg_active[31:0], 32'h1111_0001);

    // R6 write collides with event: old shadow commits, new stays pending
    do_write(8'h00, 32'h2222_0002);
    @(negedge clk); sync1_in = 1'b1;          // edge S1 next
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'h00; wr_data = 32'h3333_0003; // captured at S2
    @(negedge clk); wr_en = 1'b0;             // shadow and commit at S3
    @(negedge clk);
    check("R6 old shadow committed", cfg_active[31:0], 32'h2222_0002);
    sync1_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 new value still pending", cfg_active[31:0], 32'h2222_0002);
    do_sync(1);
    check("R6 new value on next event", cfg_active[31:0], 32'h3333_0003);

    // R7 start on sync2 selected
    do_reset();
    check("R1 cleared after reset", cfg_active[31:0], 32'h0);
    do_write(8'h10, 32'h0003_0100);
    do_sync(1);
    check("R7 unselected start source", {28'h0, proc_en}, 32'h0);
    do_sync(2);
    check("R7 start on sync2", {28'h0, proc_en}, 32'hF);

    // R8 disabled start source
    do_reset();
    do_write(8'h10, 32'h0001_0100);
    do_sync(2);
    check("R8 disabled source no start", {28'h0, proc_en}, 32'h0);

    finish_run();
  end
endmodule